// File: doc/BRIEF.md
# DDR Controller Operational State Sequencer

This block is the top-level operating-mode machine of a DDR memory controller. Software steers it by writing encoded commands (INIT, CFG, GO, SLEEP, WAKEUP) and polls a 7-bit status word. The status word holds the current controller state and a record of what caused the last low-power entry. The machine walks a fixed path: memory initialisation, then configuration, then normal access. From normal access it can enter self-refresh and later return to access. Every move passes through a transitional request state that software can observe. Software keeps polling until a stable state appears.

The two low-power moves depend on handshakes from the memory/PHY side. On entry, the block raises a self-refresh request and waits for an entry acknowledge. On exit, it drops the request and waits for both an exit acknowledge and DLL lock. Hardware can also start self-refresh entry from an idle request, but only when hardware low-power entry is enabled. The clock-enable control to the memory is low only while the block sits in the low-power state.

Top module: `ddr_opstate_seq`

## Requirements
- R1: While reset is asserted and right after it, the state is Init_mem (0), the self-refresh request is low, the trigger field is 0 and clock enable is high.
- R2: Status word layout: bits [2:0] hold the state, bit 3 always reads 0, bits [6:4] hold the low-power trigger field. Within the trigger field, bit 4 means software caused entry, bit 5 means hardware caused entry, and bit 6 always reads 0. State codes are: 0 Init_mem, 1 Config, 2 Config_req, 3 Access, 4 Access_req, 5 Low_power, 6 Low_power_entry_req, 7 Low_power_exit_req.
- R3: Command CFG (code 1) in Init_mem moves to Config_req on the next edge, then to Config one edge later.
- R4: Command GO (code 2) in Config moves to Access_req, then to Access one edge later. Access is reached only from Access_req or Low_power_exit_req, so no single command leads from Init_mem to Access.
- R5: A command that is not legal in the current state leaves the state unchanged. This covers GO or SLEEP in Init_mem, SLEEP or code 7 in Config, WAKEUP in Access, GO in Low_power, and any command in a transitional state. The command codes are INIT 0, CFG 1, GO 2, SLEEP 3, WAKEUP 4.
- R6: SLEEP (code 3) in Access moves to Low_power_entry_req and raises the self-refresh request. The machine stays there until the entry acknowledge is high at a clock edge, then moves to Low_power with the request still high.
- R7: WAKEUP (code 4) in Low_power moves to Low_power_exit_req and drops the self-refresh request. The machine stays there until the exit acknowledge and DLL lock are both high at the same edge, then moves to Access.
- R8: In Access, a hardware idle request starts the same entry sequence as SLEEP, but only when hardware low-power enable is high. The hardware idle request is ignored when the enable is low and in every state other than Access.
- R9: On entry, the trigger field becomes 001 for software or 010 for hardware. Software wins when both arrive in the same cycle. The field holds through Low_power and reads 000 from the moment WAKEUP is accepted.
- R10: Clock enable is low exactly while the state is Low_power.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | State-control command strobe, one cycle per command |
| cmdCode | input | 3 | Encoded command |
| hwLpEnable | input | 1 | Enables hardware-initiated low-power entry |
| hwIdleReq | input | 1 | Hardware idle request |
| srEntryAck | input | 1 | Self-refresh entry acknowledge from memory side |
| srExitAck | input | 1 | Self-refresh exit acknowledge from memory side |
| dllLocked | input | 1 | PHY DLL lock indication |
| statusWord | output | 7 | {trigger[2:0], 1'b0, state[2:0]} |
| srReq | output | 1 | Self-refresh request |
| ckeEn | output | 1 | Memory clock-enable control |

## Verification
Every cycle, the assertions check these properties:
- the self-refresh request is high only in the two low-power states;
- the entry state waits for its acknowledge, and the exit state waits for acknowledge plus lock;
- Access is reached only through a request state;
- clock enable tracks Low_power;
- the trigger field is empty outside the low-power states;
- Config holds until GO.

Other behaviours can only be shown by the bench's sequences. These are the one-cycle length of the Config_req and Access_req states, the exact trigger codes, software priority over a simultaneous hardware request, rejection of specific illegal commands in each state, and reset from the middle of a transition.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

  localparam int STATE_W = 3;
  localparam int CMD_W   = 3;
  localparam int TRIG_W  = 3;
  localparam int STATUS_W = TRIG_W + 1 + STATE_W;
  localparam int TRIG_SW_BIT = 0;
  localparam int TRIG_HW_BIT = 1;

  typedef enum logic [CMD_W-1:0] {
    CMD_INIT  = 3'd0,
    CMD_CFG   = 3'd1,
    CMD_GO    = 3'd2,
    CMD_SLEEP = 3'd3,
    CMD_WAKE  = 3'd4
  } seq_cmd_e;

  typedef enum logic [STATE_W-1:0] {
    ST_INIT_MEM = 3'd0,
    ST_CONFIG   = 3'd1,
    ST_CFG_REQ  = 3'd2,
    ST_ACCESS   = 3'd3,
    ST_ACC_REQ  = 3'd4,
    ST_LOWPWR   = 3'd5,
    ST_LP_ENTER = 3'd6,
    ST_LP_EXIT  = 3'd7
  } seq_state_e;

  typedef struct packed {
    logic       loadState;
    seq_state_e nextState;
    logic       setTrigSw;
    logic       setTrigHw;
    logic       clrTrig;
    logic       raiseSr;
    logic       dropSr;
  } seq_strobe_t;

endpackage

// File: rtl/ddr_seq_ctrl.sv
module ddr_seq_ctrl
  import ddr_seq_pkg::*;
(
  input  seq_state_e        curState,
  input  logic              cmdValid,
  input  logic [CMD_W-1:0]  cmdCode,
  input  logic              hwLpEnable,
  input  logic              hwIdleReq,
  input  logic              srEntryAck,
  input  logic              srExitAck,
  input  logic              dllLocked,
  output seq_strobe_t       strobe
);

  logic isCfg, isGo, isSleep, isWake, hwSleep;

  always_comb begin
    isCfg   = cmdValid && (cmdCode == CMD_CFG);
    isGo    = cmdValid && (cmdCode == CMD_GO);
    isSleep = cmdValid && (cmdCode == CMD_SLEEP);
    isWake  = cmdValid && (cmdCode == CMD_WAKE);
    hwSleep = hwLpEnable && hwIdleReq;
  end

  always_comb begin
    strobe = '0;
    strobe.nextState = curState;
    unique case (curState)
      ST_INIT_MEM: if (isCfg) begin
        strobe.loadState = 1'b1;
        strobe.nextState = ST_CFG_REQ;
      end
      ST_CFG_REQ: begin
        strobe.loadState = 1'b1;
        strobe.nextState = ST_CONFIG;
      end
      ST_CONFIG: if (isGo) begin
        strobe.loadState = 1'b1;
        strobe.nextState = ST_ACC_REQ;
      end
      ST_ACC_REQ: begin
        strobe.loadState = 1'b1;
        strobe.nextState = ST_ACCESS;
      end
      ST_ACCESS: if (isSleep || hwSleep) begin
        strobe.loadState = 1'b1;
        strobe.nextState = ST_LP_ENTER;
        strobe.raiseSr   = 1'b1;
        strobe.setTrigSw = isSleep;
        strobe.setTrigHw = !isSleep;
      end
      ST_LP_ENTER: if (srEntryAck) begin
        strobe.loadState = 1'b1;
        strobe.nextState = ST_LOWPWR;
      end
      ST_LOWPWR: if (isWake) begin
        strobe.loadState = 1'b1;
        strobe.nextState = ST_LP_EXIT;
        strobe.clrTrig   = 1'b1;
        strobe.dropSr    = 1'b1;
      end
      ST_LP_EXIT: if (srExitAck && dllLocked) begin
        strobe.loadState = 1'b1;
        strobe.nextState = ST_ACCESS;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ddr_seq_dpath.sv
module ddr_seq_dpath
  import ddr_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  seq_strobe_t         strobe,
  output seq_state_e          curState,
  output logic [TRIG_W-1:0]   trigField,
  output logic                srReqQ,
  output logic                ckeQ
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState <= ST_INIT_MEM;
      ckeQ     <= 1'b1;
    end else if (strobe.loadState) begin
      curState <= strobe.nextState;
      ckeQ     <= (strobe.nextState != ST_LOWPWR);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigField <= '0;
    end else if (strobe.clrTrig) begin
      trigField <= '0;
    end else if (strobe.setTrigSw) begin
      trigField <= TRIG_W'(1) << TRIG_SW_BIT;
    end else if (strobe.setTrigHw) begin
      trigField <= TRIG_W'(1) << TRIG_HW_BIT;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srReqQ <= 1'b0;
    end else if (strobe.raiseSr) begin
      srReqQ <= 1'b1;
    end else if (strobe.dropSr) begin
      srReqQ <= 1'b0;
    end
  end

  AST_TRIG_ONEHOT0: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(trigField)) else $error("trigger field has several sources"); // R9

  AST_SR_FOLLOWS_TRIG: assert property (@(posedge clk) disable iff (!rstN)
    (trigField != '0) |-> srReqQ) else $error("trigger set without request"); // R9

endmodule

// File: rtl/ddr_opstate_seq.sv
module ddr_opstate_seq
  import ddr_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [CMD_W-1:0]     cmdCode,
  input  logic                 hwLpEnable,
  input  logic                 hwIdleReq,
  input  logic                 srEntryAck,
  input  logic                 srExitAck,
  input  logic                 dllLocked,
  output logic [STATUS_W-1:0]  statusWord,
  output logic                 srReq,
  output logic                 ckeEn
);

  seq_strobe_t        strobe;
  seq_state_e         curState;
  logic [TRIG_W-1:0]  trigField;

  ddr_seq_ctrl u_ctrl (
    .curState   (curState),
    .cmdValid   (cmdValid),
    .cmdCode    (cmdCode),
    .hwLpEnable (hwLpEnable),
    .hwIdleReq  (hwIdleReq),
    .srEntryAck (srEntryAck),
    .srExitAck  (srExitAck),
    .dllLocked  (dllLocked),
    .strobe     (strobe)
  );

  ddr_seq_dpath u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .curState  (curState),
    .trigField (trigField),
    .srReqQ    (srReq),
    .ckeQ      (ckeEn)
  );

  assign statusWord = {trigField, 1'b0, curState};

  logic [STATE_W-1:0] stView;
  assign stView = statusWord[STATE_W-1:0];

  AST_SR_ONLY_IN_LP: assert property (@(posedge clk) disable iff (!rstN)
    srReq |-> (stView == ST_LP_ENTER || stView == ST_LOWPWR)) else $error("stray request"); // R6

  AST_ENTRY_WAITS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (stView == ST_LP_ENTER && !srEntryAck) |=> (stView == ST_LP_ENTER)) else $error("left entry early"); // R6

  AST_EXIT_WAITS_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (stView == ST_LP_EXIT && !(srExitAck && dllLocked)) |=> (stView == ST_LP_EXIT)) else $error("left exit early"); // R7

  AST_ACCESS_VIA_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (stView != ST_ACCESS && stView != ST_ACC_REQ && stView != ST_LP_EXIT) |=> (stView != ST_ACCESS)) else $error("access without request state"); // R4

  AST_CKE_TRACKS_LP: assert property (@(posedge clk) disable iff (!rstN)
    ckeEn == (stView != ST_LOWPWR)) else $error("clock enable mismatch"); // R10

  AST_TRIG_EMPTY_OUTSIDE_LP: assert property (@(posedge clk) disable iff (!rstN)
    (stView != ST_LP_ENTER && stView != ST_LOWPWR) |-> (statusWord[STATUS_W-1:STATE_W+1] == '0)) else $error("stale trigger"); // R9

  AST_CONFIG_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (stView == ST_CONFIG && !(cmdValid && cmdCode == CMD_GO)) |=> (stView == ST_CONFIG)) else $error("config left without GO"); // R5

endmodule

// File: tb/ddr_opstate_seq_tb.sv
module ddr_opstate_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 27;

  // row: [21:18] req, [17] cmdValid, [16:14] cmd, [13:9] {hwIdle,hwEn,entAck,exitAck,lock},
  //      [8:2] expected status, [1] expected srReq, [0] expected ckeEn
  localparam logic [21:0] VEC [NV] = '{
    {4'd5, 1'b1, 3'd2, 5'b00000, 7'h00, 1'b0, 1'b1}, // R5 GO in Init_mem, R4 no direct path
    {4'd5, 1'b1, 3'd3, 5'b00000, 7'h00, 1'b0, 1'b1}, // R5 SLEEP in Init_mem
    {4'd3, 1'b1, 3'd1, 5'b00000, 7'h02, 1'b0, 1'b1}, // R3 CFG -> Config_req
    {4'd3, 1'b1, 3'd1, 5'b00000, 7'h01, 1'b0, 1'b1}, // R3 Config, command in request state ignored
    {4'd5, 1'b1, 3'd3, 5'b00000, 7'h01, 1'b0, 1'b1}, // R5 SLEEP in Config
    {4'd5, 1'b1, 3'd7, 5'b00000, 7'h01, 1'b0, 1'b1}, // R5 code 7 in Config
    {4'd8, 1'b0, 3'd0, 5'b11000, 7'h01, 1'b0, 1'b1}, // R8 hw idle outside Access
    {4'd4, 1'b1, 3'd2, 5'b00000, 7'h04, 1'b0, 1'b1}, // R4 GO -> Access_req
    {4'd4, 1'b0, 3'd0, 5'b00000, 7'h03, 1'b0, 1'b1}, // R4 Access
    {4'd5, 1'b1, 3'd4, 5'b00000, 7'h03, 1'b0, 1'b1}, // R5 WAKEUP in Access
    {4'd8, 1'b0, 3'd0, 5'b10000, 7'h03, 1'b0, 1'b1}, // R8 hw idle with enable low
    {4'd6, 1'b1, 3'd3, 5'b00000, 7'h16, 1'b1, 1'b1}, // R6 R9 SLEEP -> entry req, trig 001
    {4'd6, 1'b1, 3'd4, 5'b00000, 7'h16, 1'b1, 1'b1}, // R6 waits for ack, WAKEUP ignored
    {4'd6, 1'b0, 3'd0, 5'b00100, 7'h15, 1'b1, 1'b0}, // R6 R10 ack -> Low_power, cke low
    {4'd5, 1'b1, 3'd2, 5'b00000, 7'h15, 1'b1, 1'b0}, // R5 GO in Low_power
    {4'd7, 1'b1, 3'd4, 5'b00000, 7'h07, 1'b0, 1'b1}, // R7 R9 WAKEUP -> exit req, trig cleared
    {4'd7, 1'b0, 3'd0, 5'b00010, 7'h07, 1'b0, 1'b1}, // R7 ack without lock
    {4'd7, 1'b0, 3'd0, 5'b00001, 7'h07, 1'b0, 1'b1}, // R7 lock without ack
    {4'd7, 1'b0, 3'd0, 5'b00011, 7'h03, 1'b0, 1'b1}, // R7 both -> Access
    {4'd8, 1'b0, 3'd0, 5'b11000, 7'h26, 1'b1, 1'b1}, // R8 hw entry, trig 010
    {4'd8, 1'b0, 3'd0, 5'b01100, 7'h25, 1'b1, 1'b0}, // R8 R10 ack -> Low_power
    {4'd9, 1'b1, 3'd4, 5'b00011, 7'h07, 1'b0, 1'b1}, // R9 WAKEUP clears hw trig
    {4'd7, 1'b0, 3'd0, 5'b00011, 7'h03, 1'b0, 1'b1}, // R7 back to Access
    {4'd9, 1'b1, 3'd3, 5'b11000, 7'h16, 1'b1, 1'b1}, // R9 software wins over hardware
    {4'd9, 1'b0, 3'd0, 5'b00100, 7'h15, 1'b1, 1'b0}, // R9 trig held in Low_power
    {4'd9, 1'b1, 3'd4, 5'b00000, 7'h07, 1'b0, 1'b1}, // R9 cleared on WAKEUP
    {4'd2, 1'b0, 3'd0, 5'b00011, 7'h03, 1'b0, 1'b1}  // R2 reserved bits zero in Access
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdCode = '0;
  logic hwLpEnable = 1'b0, hwIdleReq = 1'b0, srEntryAck = 1'b0, srExitAck = 1'b0, dllLocked = 1'b0;
  logic [6:0] statusWord;
  logic srReq, ckeEn;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_opstate_seq u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .hwLpEnable(hwLpEnable), .hwIdleReq(hwIdleReq), .srEntryAck(srEntryAck),
    .srExitAck(srExitAck), .dllLocked(dllLocked),
    .statusWord(statusWord), .srReq(srReq), .ckeEn(ckeEn)
  );

  task automatic check(input int req, input logic [6:0] expStat, input logic expSr, input logic expCke);
    total++;
    if (statusWord !== expStat || srReq !== expSr || ckeEn !== expCke) begin
      bad++;
      $display("FAIL R%0d: stat=%h sr=%b cke=%b expected stat=%h sr=%b cke=%b",
               req, statusWord, srReq, ckeEn, expStat, expSr, expCke);
    end
  endtask

  initial begin
    #(CLK_PERIOD*2000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run hung");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, 7'h00, 1'b0, 1'b1); // R1 during reset
    rstN = 1'b1;
    @(negedge clk);
    check(1, 7'h00, 1'b0, 1'b1); // R1 after release, no stimulus

    for (int i = 0; i < NV; i++) begin
      cmdValid   = VEC[i][17];
      cmdCode    = VEC[i][16:14];
      hwIdleReq  = VEC[i][13];
      hwLpEnable = VEC[i][12];
      srEntryAck = VEC[i][11];
      srExitAck  = VEC[i][10];
      dllLocked  = VEC[i][9];
      @(negedge clk);
      check(int'(VEC[i][21:18]), VEC[i][8:2], VEC[i][1], VEC[i][0]);
    end

    // R6: long wait for entry acknowledge
    cmdValid = 1'b1; cmdCode = 3'd3;
    hwIdleReq = 1'b0; hwLpEnable = 1'b0; srEntryAck = 1'b0; srExitAck = 1'b0; dllLocked = 1'b0;
    @(negedge clk);
    cmdValid = 1'b0;
    repeat (5) @(negedge clk);
    check(6, 7'h16, 1'b1, 1'b1); // R6 still waiting

    // R1: reset in the middle of the entry handshake
    rstN = 1'b0;
    #1;
    check(1, 7'h00, 1'b0, 1'b1);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(1, 7'h00, 1'b0, 1'b1);

    // R3 R4: CFG then GO back-to-back reach Access in four edges
    cmdValid = 1'b1; cmdCode = 3'd1;
    @(negedge clk);
    cmdCode = 3'd2;
    @(negedge clk); // Config_req -> Config, GO ignored in request state
    check(3, 7'h01, 1'b0, 1'b1);
    @(negedge clk);
    cmdValid = 1'b0;
    check(4, 7'h04, 1'b0, 1'b1);
    @(negedge clk);
    check(4, 7'h03, 1'b0, 1'b1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule